// File: doc/BRIEF.md
# ECC error capture register

This block sits beside an external single-error-correct, double-error-detect checker on a memory read path. It records the first ECC event the checker reports. The checker signals events with a correctable strobe or an uncorrectable strobe. With each strobe it presents the failing 32-bit address and the 8-bit syndrome. The block keeps the upper 19 address bits, the syndrome and a sticky flag for the kind of error. All of these sit in one 32-bit control/status word. Software reads that word directly and writes it through a single-cycle write port.

The same word holds three enable bits that software may set or clear:
- a scrub disable bit, which stops the write-back request issued after a corrected read;
- an enable for the system-error request on an uncorrectable error;
- an enable for the non-maskable interrupt request on a correctable error.

Only the first error is kept. Software clears the flags by writing ones to them, and a new error is logged only once both flags are clear.

Top module: `ecc_cap_reg`

Register layout of `reg_rdata_o` / `reg_wdata_i`:
- bit 31: scrub disable (read/write)
- bits 30:12: address bits 31:13 of the captured error (read-only)
- bits 11:4: captured syndrome (read-only)
- bit 3: system-error enable (read/write)
- bit 2: NMI enable (read/write)
- bit 1: uncorrectable flag (write 1 to clear)
- bit 0: correctable flag (write 1 to clear)

## Requirements
- R1: After reset `reg_rdata_o` reads 0, and `nmi_o`, `serr_o` and `scrub_req_o` are 0.
- R2: With both flags clear, `ce_i` sets bit 0 after the next rising edge. In the same update, bits 30:12 take `err_addr_i[31:13]` and bits 11:4 take `syndrome_i`.
- R3: With both flags clear, `ue_i` sets bit 1 after the next rising edge and captures the address and syndrome into the same fields as in R2.
- R4: When `ce_i` and `ue_i` arrive in the same cycle with both flags clear, only bit 1 is set, and the address and syndrome of that cycle are captured.
- R5: While either flag is set, any later `ce_i` or `ue_i` leaves bits 30:0 of the word unchanged.
- R6: A write with bit 0 or bit 1 of `reg_wdata_i` set clears that flag, and a zero in those bit positions leaves the flag as it is. An error is logged again only after both flags read 0.
- R7: Bits 31, 3 and 2 take the written value on every write. Writes to bits 30:4 are ignored.
- R8: `scrub_req_o` is high for the one cycle after each cycle with `ce_i` high, provided bit 31 was 0 in that cycle. This holds whether or not the error is logged. With bit 31 at 1 it stays low.
- R9: `nmi_o` is a single-cycle pulse that appears together with bit 0 becoming set, and only if bit 2 was 1 before that edge. At no other time is it high.
- R10: `serr_o` is a single-cycle pulse that appears together with bit 1 becoming set, and only if bit 3 was 1 before that edge. At no other time is it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Correctable error strobe from the checker |
| ue_i | input | 1 | Uncorrectable error strobe from the checker |
| err_addr_i | input | 32 | Failing address presented with a strobe |
| syndrome_i | input | 8 | ECC syndrome presented with a strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register value |
| nmi_o | output | 1 | NMI request pulse |
| serr_o | output | 1 | System-error request pulse |
| scrub_req_o | output | 1 | Scrub write-back request pulse |

## Verification
The assertions check the following on every cycle:
- the two flags are never set together;
- the captured fields hold still while a flag is set;
- every NMI or system-error pulse coincides with its own flag rising and lasts one cycle;
- a scrub request always follows a correctable strobe seen while scrubbing was enabled.

The assertions cannot show that a pulse was owed but missing, that a flag survives a zero write, or which error wins a simultaneous arrival. The directed scenarios cover those cases, and a per-cycle behavioural model covers them again under random strobes and writes.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned CSR_W         = 32;
  localparam int unsigned SYND_W        = 8;
  localparam int unsigned SBE_BIT       = 0;
  localparam int unsigned MBE_BIT       = 1;
  localparam int unsigned NMI_EN_BIT    = 2;
  localparam int unsigned SERR_EN_BIT   = 3;
  localparam int unsigned SYND_LSB      = 4;
  localparam int unsigned FADDR_LSB     = SYND_LSB + SYND_W;
  localparam int unsigned SCRUB_DIS_BIT = CSR_W - 1;
  localparam int unsigned FADDR_W       = SCRUB_DIS_BIT - FADDR_LSB;

  typedef struct packed {
    logic scrub_dis;
    logic serr_en;
    logic nmi_en;
  } ctl_t;

  typedef struct packed {
    logic [FADDR_W-1:0] addr;
    logic [SYND_W-1:0]  syn;
  } capt_t;
endpackage

// File: rtl/ecc_cap_ctl.sv
module ecc_cap_ctl
  import ecc_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  ctl_t wr_ctl_i,
  output ctl_t ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wr_ctl_i;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ue_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYND_W-1:0] syndrome_i,
  input  logic              we_i,
  input  logic [1:0]        clr_i,
  output logic              sbe_o,
  output logic              mbe_o,
  output logic              set_sbe_o,
  output logic              set_mbe_o,
  output capt_t             capt_o
);
  localparam int unsigned DROP_W = ADDR_W - FADDR_W;

  logic  sbe_q, mbe_q, idle;
  capt_t capt_q;
  logic  unused_addr_lo;

  assign unused_addr_lo = ^err_addr_i[DROP_W-1:0];
  assign idle           = !sbe_q && !mbe_q;
  // uncorrectable wins a tie
  assign set_mbe_o      = idle && ue_i;
  assign set_sbe_o      = idle && ce_i && !ue_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
      capt_q <= '0;
    end else begin
      sbe_q <= set_sbe_o | (sbe_q & ~(we_i & clr_i[SBE_BIT]));
      mbe_q <= set_mbe_o | (mbe_q & ~(we_i & clr_i[MBE_BIT]));
      if (set_sbe_o || set_mbe_o) begin
        capt_q.addr <= err_addr_i[ADDR_W-1 -: FADDR_W];
        capt_q.syn  <= syndrome_i;
      end
    end
  end

  assign sbe_o  = sbe_q;
  assign mbe_o  = mbe_q;
  assign capt_o = capt_q;
endmodule

// File: rtl/ecc_cap_evt.sv
module ecc_cap_evt
  import ecc_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic set_sbe_i,
  input  logic set_mbe_i,
  input  ctl_t ctl_i,
  output logic nmi_o,
  output logic serr_o,
  output logic scrub_req_o
);
  logic nmi_q, serr_q, scrub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q   <= 1'b0;
      serr_q  <= 1'b0;
      scrub_q <= 1'b0;
    end else begin
      nmi_q   <= set_sbe_i && ctl_i.nmi_en;
      serr_q  <= set_mbe_i && ctl_i.serr_en;
      scrub_q <= ce_i && !ctl_i.scrub_dis;
    end
  end

  assign nmi_o       = nmi_q;
  assign serr_o      = serr_q;
  assign scrub_req_o = scrub_q;
endmodule

// File: rtl/ecc_cap_reg.sv
module ecc_cap_reg
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ue_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYND_W-1:0] syndrome_i,
  input  logic              reg_we_i,
  input  logic [CSR_W-1:0]  reg_wdata_i,
  output logic [CSR_W-1:0]  reg_rdata_o,
  output logic              nmi_o,
  output logic              serr_o,
  output logic              scrub_req_o
);
  ctl_t  wr_ctl, ctl;
  capt_t capt;
  logic  sbe, mbe, set_sbe, set_mbe;
  logic  unused_wdata_ro;

  assign unused_wdata_ro   = ^reg_wdata_i[SCRUB_DIS_BIT-1:SYND_LSB];
  assign wr_ctl.scrub_dis  = reg_wdata_i[SCRUB_DIS_BIT];
  assign wr_ctl.serr_en    = reg_wdata_i[SERR_EN_BIT];
  assign wr_ctl.nmi_en     = reg_wdata_i[NMI_EN_BIT];

  ecc_cap_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wr_ctl_i (wr_ctl),
    .ctl_o    (ctl)
  );

  ecc_cap_log #(.ADDR_W(ADDR_W)) u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_i),
    .ue_i       (ue_i),
    .err_addr_i (err_addr_i),
    .syndrome_i (syndrome_i),
    .we_i       (reg_we_i),
    .clr_i      (reg_wdata_i[MBE_BIT:SBE_BIT]),
    .sbe_o      (sbe),
    .mbe_o      (mbe),
    .set_sbe_o  (set_sbe),
    .set_mbe_o  (set_mbe),
    .capt_o     (capt)
  );

  ecc_cap_evt u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce_i),
    .set_sbe_i   (set_sbe),
    .set_mbe_i   (set_mbe),
    .ctl_i       (ctl),
    .nmi_o       (nmi_o),
    .serr_o      (serr_o),
    .scrub_req_o (scrub_req_o)
  );

  always_comb begin
    reg_rdata_o                                 = '0;
    reg_rdata_o[SCRUB_DIS_BIT]                  = ctl.scrub_dis;
    reg_rdata_o[FADDR_LSB +: FADDR_W]           = capt.addr;
    reg_rdata_o[SYND_LSB +: SYND_W]             = capt.syn;
    reg_rdata_o[SERR_EN_BIT]                    = ctl.serr_en;
    reg_rdata_o[NMI_EN_BIT]                     = ctl.nmi_en;
    reg_rdata_o[MBE_BIT]                        = mbe;
    reg_rdata_o[SBE_BIT]                        = sbe;
  end
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_i,
  input logic [31:0] reg_rdata_o,
  input logic        nmi_o,
  input logic        serr_o,
  input logic        scrub_req_o
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rdata_o[0] && reg_rdata_o[1])); // R4
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_rdata_o[1:0]) |=> $stable(reg_rdata_o[30:4])); // R5
  AST_SCRUB_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_req_o |-> ($past(ce_i) && !$past(reg_rdata_o[31]))); // R8
  AST_NMI_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> ($rose(reg_rdata_o[0]) && $past(reg_rdata_o[2]))); // R9
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o); // R9
  AST_SERR_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> ($rose(reg_rdata_o[1]) && $past(reg_rdata_o[3]))); // R10
  AST_SERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |=> !serr_o); // R10
endmodule

bind ecc_cap_reg ecc_cap_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_i        (ce_i),
  .reg_rdata_o (reg_rdata_o),
  .nmi_o       (nmi_o),
  .serr_o      (serr_o),
  .scrub_req_o (scrub_req_o)
);

// File: tb/tb_ecc_cap_reg.sv
`timescale 1ns/1ps
module tb_ecc_cap_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce = 1'b0, ue = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wd = '0;
  logic [7:0]  syn = '0;
  logic [31:0] rdata;
  logic        nmi, serr, scrub;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ecc_cap_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .ue_i(ue),
    .err_addr_i(addr), .syndrome_i(syn), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .nmi_o(nmi), .serr_o(serr), .scrub_req_o(scrub)
  );

  // behavioural reference, updated per edge
  logic        m_sbe, m_mbe, m_dis, m_sen, m_nen, m_nmi, m_serr, m_scrub;
  logic [18:0] m_addr;
  logic [7:0]  m_syn;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_sbe, m_mbe, m_dis, m_sen, m_nen, m_nmi, m_serr, m_scrub} <= '0;
      m_addr <= '0; m_syn <= '0;
    end else begin
      m_scrub <= ce && !m_dis;
      m_nmi   <= 1'b0;
      m_serr  <= 1'b0;
      if (!m_sbe && !m_mbe && (ce || ue)) begin
        m_addr <= addr >> 13;
        m_syn  <= syn;
        if (ue) begin m_mbe <= 1'b1; m_serr <= m_sen; end
        else    begin m_sbe <= 1'b1; m_nmi  <= m_nen; end
      end else if (we) begin
        if (wd[0]) m_sbe <= 1'b0;
        if (wd[1]) m_mbe <= 1'b0;
      end
      if (we) begin m_dis <= wd[31]; m_sen <= wd[3]; m_nen <= wd[2]; end
    end
  end

  function automatic logic [31:0] pack(input logic dis, input logic [31:0] a,
      input logic [7:0] s, input logic sen, input logic nen,
      input logic mb, input logic sb);
    return {dis, a[31:13], s, sen, nen, mb, sb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R6 model rdata", rdata, {m_dis, m_addr, m_syn, m_sen, m_nen, m_mbe, m_sbe});
      chk("R9 model nmi", {31'd0, nmi}, {31'd0, m_nmi});
      chk("R10 model serr", {31'd0, serr}, {31'd0, m_serr});
      chk("R8 model scrub", {31'd0, scrub}, {31'd0, m_scrub});
    end
  end

  task automatic step(input logic c, input logic u, input logic [31:0] a,
      input logic [7:0] s, input logic w, input logic [31:0] d);
    ce = c; ue = u; addr = a; syn = s; we = w; wd = d;
    @(negedge clk);
    ce = 0; ue = 0; we = 0;
  endtask

  task automatic idle(); step(0, 0, 32'h0, 8'h0, 0, 32'h0); endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a1, a2, a3;
    a1 = 32'hABCD_E123; a2 = 32'h1234_5678; a3 = 32'hFEDC_BA98;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset outputs", {29'd0, nmi, serr, scrub}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", rdata, 32'h0);

    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R7 rw bits only", rdata, 32'h8000_000C);
    step(0, 0, 0, 0, 1, 32'h0000_000C);
    chk("R7 enables rewritten", rdata, 32'h0000_000C);

    step(1, 0, a1, 8'h5A, 0, 0);
    chk("R2 ce capture", rdata, pack(0, a1, 8'h5A, 1, 1, 0, 1));
    chk("R9 nmi pulse", {31'd0, nmi}, 32'd1);
    chk("R8 scrub pulse", {31'd0, scrub}, 32'd1);
    idle();
    chk("R9 nmi single cycle", {31'd0, nmi}, 32'd0);
    chk("R8 scrub single cycle", {31'd0, scrub}, 32'd0);

    step(0, 1, a2, 8'h33, 0, 0);
    chk("R5 ue ignored while logged", rdata, pack(0, a1, 8'h5A, 1, 1, 0, 1));
    chk("R10 no serr when not logged", {31'd0, serr}, 32'd0);
    step(1, 0, a2, 8'h33, 0, 0);
    chk("R5 ce ignored while logged", rdata, pack(0, a1, 8'h5A, 1, 1, 0, 1));
    chk("R8 scrub on unlogged ce", {31'd0, scrub}, 32'd1);
    chk("R9 no nmi when not logged", {31'd0, nmi}, 32'd0);

    step(0, 0, 0, 0, 1, 32'h0000_000C);
    chk("R6 zero write keeps flag", rdata, pack(0, a1, 8'h5A, 1, 1, 0, 1));
    step(0, 0, 0, 0, 1, 32'h0000_000D);
    chk("R6 w1c clears flag", rdata, pack(0, a1, 8'h5A, 1, 1, 0, 0));

    step(1, 1, a3, 8'hC3, 0, 0);
    chk("R4 tie logs ue only", rdata, pack(0, a3, 8'hC3, 1, 1, 1, 0));
    chk("R4 tie no nmi", {31'd0, nmi}, 32'd0);
    chk("R10 serr pulse", {31'd0, serr}, 32'd1);
    idle();
    chk("R10 serr single cycle", {31'd0, serr}, 32'd0);

    step(0, 0, 0, 0, 1, 32'h0000_000D);
    chk("R6 clearing wrong flag keeps ue", rdata, pack(0, a3, 8'hC3, 1, 1, 1, 0));
    step(1, 0, a1, 8'h11, 0, 0);
    chk("R6 no log until both clear", rdata, pack(0, a3, 8'hC3, 1, 1, 1, 0));
    step(0, 0, 0, 0, 1, 32'h0000_000E);
    chk("R6 both clear", rdata[1:0], 32'h0);

    step(0, 1, a2, 8'h77, 0, 0);
    chk("R3 ue capture", rdata, pack(0, a2, 8'h77, 1, 1, 1, 0));
    step(0, 0, 0, 0, 1, 32'h8000_0003);
    chk("R6 clear with enables off", rdata, pack(1, a2, 8'h77, 0, 0, 0, 0));

    step(1, 0, a3, 8'h99, 0, 0);
    chk("R2 ce capture enables off", rdata, pack(1, a3, 8'h99, 0, 0, 0, 1));
    chk("R9 nmi gated off", {31'd0, nmi}, 32'd0);
    chk("R8 scrub disabled", {31'd0, scrub}, 32'd0);
    step(0, 0, 0, 0, 1, 32'h8000_0001);
    step(0, 1, a1, 8'h44, 0, 0);
    chk("R10 serr gated off", {31'd0, serr}, 32'd0);
    chk("R3 ue capture enables off", rdata, pack(1, a1, 8'h44, 0, 0, 1, 0));

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] == 0, r[7:4] == 0, $urandom, r[15:8], r[19:16] < 3,
           {r[20], 27'h0, r[23:21], r[24]});
    end
    finish_run();
  end
endmodule